// File: doc/BRIEF.md
# Physical memory protection permission checker

This block decides whether a single memory access may proceed under a table of protection entries. A request carries the access address, the access size in bytes, a flag telling whether the requester runs in machine mode or in a lower privilege mode, and the set of read, write and execute rights it needs. The block tests the first and the last byte of the access against the decoded bounds of every entry at once. The entry with the lowest index whose range touches the access decides the outcome. When no entry decides, a set of default rules applies, and these depend on two security-mode inputs: a deny-by-default (whitelist) bit and a machine-mode lockdown bit.

The entry bounds, the configuration bytes and the count of active entries come from elsewhere in the chip. The checker only reads them. The allowed rights and a grant flag come out of a register one clock after a valid request, so one request can be accepted on every cycle. Under lockdown, a matched entry's rights come from one of two sixteen-entry tables, one for machine mode and one for lower modes. Each table is indexed by the entry's lock, read, write and execute bits.

Top module: `pmp_perm_check`

## Requirements
- R1: A request presented with `req_valid_i` high gives `rsp_valid_o` high on the next rising clock edge, carrying that request's result. A cycle without a request gives `rsp_valid_o` low on the next edge. `rsp_allow_o` and `rsp_grant_o` keep their last values while no request arrives.
- R2: The entry that decides is the active entry with the lowest index whose inclusive range [lo, hi] contains the first byte or the last byte of the access. Entries with higher indices have no effect.
- R3: If the deciding entry contains exactly one of the first and last bytes, the access is denied: `rsp_allow_o` = 0 and `rsp_grant_o` = 0.
- R4: The last byte is address + size − 1, taken modulo 2^ADDR_W. A size of zero counts as a 4-byte access.
- R5: An entry is active only when its match-mode field (configuration bits [4:3]) is nonzero and the active-rule count is nonzero. Inactive entries are skipped. If the count is zero or no active entry decides, the default rules apply.
- R6: The default rules are applied in this order. With the whitelist bit set, the allowed set is empty. Otherwise, with lockdown set, a machine-mode request that does not ask for X gets R+W and every other request gets nothing. Otherwise machine mode gets R+W+X and lower modes get nothing.
- R7: Without lockdown, a fully covering entry gives machine mode R+W+X when its lock bit (configuration bit 7) is clear. Lower modes, and machine mode on a locked entry, get the entry's own R, W and X bits (configuration bits 0, 1 and 2).
- R8: Under lockdown, a fully covering entry gives machine mode a set chosen by code = {L,R,W,X}, with L as the most significant bit. Codes 2, 3 and 14 give R+W. Codes 9 and 10 give X. Codes 11 and 13 give R+X. Codes 12 and 15 give R. All other codes give nothing.
- R9: Under lockdown, a fully covering entry gives a lower mode a set chosen by the same code. Code 7 gives R+W+X. Code 5 gives R+X. Codes 3 and 6 give R+W. Codes 2, 4 and 15 give R. Codes 1, 10 and 11 give X. All other codes give nothing.
- R10: `rsp_grant_o` is 1 exactly when no partial-overlap denial occurred and the requested set is a subset of the allowed set. Rights are encoded as bit 0 = R, bit 1 = W, bit 2 = X.
- R11: While reset is asserted, `rsp_valid_o`, `rsp_allow_o` and `rsp_grant_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ent_lo_i | input | NUM_ENT*ADDR_W | Inclusive lower byte bound of each entry, entry 0 in the least significant slice |
| ent_hi_i | input | NUM_ENT*ADDR_W | Inclusive upper byte bound of each entry |
| ent_cfg_i | input | NUM_ENT*8 | Configuration byte of each entry: [0] R, [1] W, [2] X, [4:3] match mode, [7] lock |
| rule_cnt_i | input | CNT_W | Number of active rules |
| sec_wl_i | input | 1 | Deny-by-default (whitelist) bit |
| sec_lockdown_i | input | 1 | Machine-mode lockdown bit |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Address of the first byte |
| req_size_i | input | SIZE_W | Access size in bytes; 0 means 4 |
| req_mach_i | input | 1 | 1 = machine mode, 0 = lower mode |
| req_perm_i | input | 3 | Requested rights: [0] R, [1] W, [2] X |
| rsp_valid_o | output | 1 | Result present |
| rsp_allow_o | output | 3 | Allowed rights |
| rsp_grant_o | output | 1 | Access permitted |

## Verification
Overlapping entries with different rights show whether the lowest-index entry wins (R2). An access that straddles the edge of a high-priority entry but lies fully inside a lower-priority one separates partial-overlap denial from a plain fall-through to the next entry (R3, R4). An inactive entry placed over an active one tests the skip rule (R5). The default rules are driven under each combination of the whitelist and lockdown bits. All sixteen lockdown codes are swept for both privilege levels, so any swapped table row shows up. A long run of mixed requests is then compared against a behavioural model on every clock.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef logic [2:0] perm_t;

  localparam int unsigned CFG_R    = 0;
  localparam int unsigned CFG_W    = 1;
  localparam int unsigned CFG_X    = 2;
  localparam int unsigned CFG_MLO  = 3;
  localparam int unsigned CFG_MHI  = 4;
  localparam int unsigned CFG_LOCK = 7;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // lockdown code {L,R,W,X} formed from a configuration byte
  function automatic logic [3:0] ld_code(input logic [7:0] cfg);
    return {cfg[CFG_LOCK], cfg[CFG_R], cfg[CFG_W], cfg[CFG_X]};
  endfunction

  // machine-mode rights under lockdown
  function automatic perm_t ld_mach(input logic [3:0] code);
    perm_t p;
    unique case (code)
      4'd2, 4'd3, 4'd14: p = P_RW;
      4'd9, 4'd10:       p = P_X;
      4'd11, 4'd13:      p = P_RX;
      4'd12, 4'd15:      p = P_R;
      default:           p = P_NONE;
    endcase
    return p;
  endfunction

  // lower-mode rights under lockdown
  function automatic perm_t ld_user(input logic [3:0] code);
    perm_t p;
    unique case (code)
      4'd7:                p = P_RWX;
      4'd5:                p = P_RX;
      4'd3, 4'd6:          p = P_RW;
      4'd2, 4'd4, 4'd15:   p = P_R;
      4'd1, 4'd10, 4'd11:  p = P_X;
      default:             p = P_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pmp_chk_span.sv
module pmp_chk_span #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SIZE_W   = 4,
  parameter int unsigned DEF_SIZE = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] last_o
);
  logic [ADDR_W-1:0] eff_size;

  always_comb begin
    if (size_i == '0) eff_size = ADDR_W'(DEF_SIZE);
    else              eff_size = ADDR_W'(size_i);
    last_o = addr_i + eff_size - ADDR_W'(1);
  end
endmodule

// File: rtl/pmp_chk_entry.sv
module pmp_chk_entry #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [7:0]        cfg_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic              full_o,
  output logic              part_o
);
  import pmp_chk_pkg::*;

  logic active;
  logic in_first;
  logic in_last;

  always_comb begin
    active   = enable_i && (cfg_i[CFG_MHI:CFG_MLO] != 2'b00);
    in_first = (first_i >= lo_i) && (first_i <= hi_i);
    in_last  = (last_i  >= lo_i) && (last_i  <= hi_i);
    full_o   = active && in_first && in_last;
    part_o   = active && (in_first ^ in_last);
  end
endmodule

// File: rtl/pmp_chk_prio.sv
module pmp_chk_prio #(
  parameter int unsigned NUM_ENT = 8,
  localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT-1:0]   full_i,
  input  logic [NUM_ENT-1:0]   part_i,
  input  logic [NUM_ENT*8-1:0] cfg_i,
  output logic                 found_o,
  output logic                 part_o,
  output logic [7:0]           cfg_o
);
  logic [IDX_W-1:0] sel;
  logic             any;

  // scan downward so the lowest index written last wins
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (full_i[i] || part_i[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
    found_o = any && full_i[sel];
    part_o  = any && part_i[sel];
    cfg_o   = cfg_i[sel*8 +: 8];
  end
endmodule

// File: rtl/pmp_chk_resolve.sv
module pmp_chk_resolve (
  input  logic                found_i,
  input  logic                part_i,
  input  logic [7:0]          cfg_i,
  input  logic                mach_i,
  input  logic                wl_i,
  input  logic                lockdown_i,
  input  pmp_chk_pkg::perm_t  req_i,
  output pmp_chk_pkg::perm_t  allow_o,
  output logic                grant_o
);
  import pmp_chk_pkg::*;

  perm_t def_perm;
  perm_t hit_perm;

  always_comb begin
    if (wl_i)
      def_perm = P_NONE;
    else if (lockdown_i)
      def_perm = (mach_i && !req_i[CFG_X]) ? P_RW : P_NONE;
    else
      def_perm = mach_i ? P_RWX : P_NONE;
  end

  always_comb begin
    if (!lockdown_i)
      hit_perm = (mach_i && !cfg_i[CFG_LOCK]) ? P_RWX : cfg_i[CFG_X:CFG_R];
    else if (mach_i)
      hit_perm = ld_mach(ld_code(cfg_i));
    else
      hit_perm = ld_user(ld_code(cfg_i));
  end

  always_comb begin
    if (part_i)       allow_o = P_NONE;
    else if (found_i) allow_o = hit_perm;
    else              allow_o = def_perm;
    grant_o = !part_i && ((req_i & ~allow_o) == P_NONE);
  end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check #(
  parameter int unsigned NUM_ENT  = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SIZE_W   = 4,
  parameter int unsigned DEF_SIZE = 4,
  localparam int unsigned CNT_W   = $clog2(NUM_ENT + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_ENT*ADDR_W-1:0] ent_lo_i,
  input  logic [NUM_ENT*ADDR_W-1:0] ent_hi_i,
  input  logic [NUM_ENT*8-1:0]      ent_cfg_i,
  input  logic [CNT_W-1:0]          rule_cnt_i,
  input  logic                      sec_wl_i,
  input  logic                      sec_lockdown_i,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [SIZE_W-1:0]         req_size_i,
  input  logic                      req_mach_i,
  input  logic [2:0]                req_perm_i,
  output logic                      rsp_valid_o,
  output logic [2:0]                rsp_allow_o,
  output logic                      rsp_grant_o
);
  import pmp_chk_pkg::*;

  logic [ADDR_W-1:0]  last_addr;
  logic [NUM_ENT-1:0] full_vec;
  logic [NUM_ENT-1:0] part_vec;
  logic               rules_on;
  logic               hit_found;
  logic               hit_part;
  logic [7:0]         hit_cfg;
  perm_t              allow_d;
  logic               grant_d;

  logic               valid_q, valid_d;
  perm_t              allow_q, allow_nx;
  logic               grant_q, grant_nx;

  assign rules_on = (rule_cnt_i != '0);

  pmp_chk_span #(
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .DEF_SIZE(DEF_SIZE)
  ) u_span (
    .addr_i(req_addr_i),
    .size_i(req_size_i),
    .last_o(last_addr)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    pmp_chk_entry #(.ADDR_W(ADDR_W)) u_ent (
      .enable_i(rules_on),
      .lo_i    (ent_lo_i[g*ADDR_W +: ADDR_W]),
      .hi_i    (ent_hi_i[g*ADDR_W +: ADDR_W]),
      .cfg_i   (ent_cfg_i[g*8 +: 8]),
      .first_i (req_addr_i),
      .last_i  (last_addr),
      .full_o  (full_vec[g]),
      .part_o  (part_vec[g])
    );
  end

  pmp_chk_prio #(.NUM_ENT(NUM_ENT)) u_prio (
    .full_i (full_vec),
    .part_i (part_vec),
    .cfg_i  (ent_cfg_i),
    .found_o(hit_found),
    .part_o (hit_part),
    .cfg_o  (hit_cfg)
  );

  pmp_chk_resolve u_resolve (
    .found_i   (hit_found),
    .part_i    (hit_part),
    .cfg_i     (hit_cfg),
    .mach_i    (req_mach_i),
    .wl_i      (sec_wl_i),
    .lockdown_i(sec_lockdown_i),
    .req_i     (req_perm_i),
    .allow_o   (allow_d),
    .grant_o   (grant_d)
  );

  // next state: capture only on a request
  always_comb begin
    valid_d  = req_valid_i;
    allow_nx = allow_q;
    grant_nx = grant_q;
    if (req_valid_i) begin
      allow_nx = allow_d;
      grant_nx = grant_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      allow_q <= P_NONE;
      grant_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      allow_q <= allow_nx;
      grant_q <= grant_nx;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_allow_o = allow_q;
  assign rsp_grant_o = grant_q;

  // R1: response strobe tracks the request one cycle later
  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R3: partial overlap on the deciding entry denies everything
  a_r3_partial_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_part) |=> (rsp_allow_o == 3'b000 && !rsp_grant_o));

  // R6: whitelist default gives nothing
  a_r6_whitelist_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sec_wl_i && !hit_found && !hit_part) |=> (rsp_allow_o == 3'b000));

  // R7: unlocked hit in machine mode without lockdown gives every right
  a_r7_mach_unlocked_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !sec_lockdown_i && hit_found && req_mach_i && !hit_cfg[CFG_LOCK])
    |=> (rsp_allow_o == 3'b111));

  // R8 / R9: lockdown never grants write without read
  a_r8_lockdown_no_bare_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sec_lockdown_i) |=> !(rsp_allow_o[1] && !rsp_allow_o[0]));

  // R10: a grant never exceeds the allowed set of the same request
  a_r10_grant_within_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && grant_d) |-> ((req_perm_i & ~allow_d) == 3'b000));
endmodule

// File: tb/pmp_perm_check_bench.sv
`timescale 1ns/1ps
module pmp_perm_check_bench;
  localparam int NE = 8;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int CW = $clog2(NE + 1);

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [AW-1:0] lo_a [NE];
  logic [AW-1:0] hi_a [NE];
  logic [7:0]    cf_a [NE];
  logic [NE*AW-1:0] lo_f, hi_f;
  logic [NE*8-1:0]  cf_f;
  logic [CW-1:0] cnt;
  logic wl, ld, rv, rm;
  logic [AW-1:0] ra;
  logic [SW-1:0] rs;
  logic [2:0] rp;
  logic ov;
  logic [2:0] oa;
  logic og;

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      lo_f[i*AW +: AW] = lo_a[i];
      hi_f[i*AW +: AW] = hi_a[i];
      cf_f[i*8 +: 8]   = cf_a[i];
    end
  end

  pmp_perm_check u_pmp_perm_check (
    .clk_i(clk), .rst_ni(rst_n),
    .ent_lo_i(lo_f), .ent_hi_i(hi_f), .ent_cfg_i(cf_f),
    .rule_cnt_i(cnt), .sec_wl_i(wl), .sec_lockdown_i(ld),
    .req_valid_i(rv), .req_addr_i(ra), .req_size_i(rs),
    .req_mach_i(rm), .req_perm_i(rp),
    .rsp_valid_o(ov), .rsp_allow_o(oa), .rsp_grant_o(og)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit run_chk = 0;
  string cur_tag = "R1";

  // behavioural tables written from R8 / R9 as lists of codes
  function automatic logic [2:0] tbl_m(int c);
    if (c == 2 || c == 3 || c == 14) return 3'b011;
    if (c == 9 || c == 10) return 3'b100;
    if (c == 11 || c == 13) return 3'b101;
    if (c == 12 || c == 15) return 3'b001;
    return 3'b000;
  endfunction
  function automatic logic [2:0] tbl_u(int c);
    if (c == 7) return 3'b111;
    if (c == 5) return 3'b101;
    if (c == 3 || c == 6) return 3'b011;
    if (c == 2 || c == 4 || c == 15) return 3'b001;
    if (c == 1 || c == 10 || c == 11) return 3'b100;
    return 3'b000;
  endfunction

  task automatic model(output logic [2:0] al, output logic gr);
    longint unsigned a, sz, last, lo, hi;
    bit fi, li, decided, part;
    int code;
    a  = ra;
    sz = (rs == 0) ? 4 : rs;
    last = (a + sz - 1) % (64'd1 << AW);
    decided = 0; part = 0; al = 3'b000;
    if (cnt != 0) begin
      for (int i = 0; i < NE; i++) begin
        if (!decided && cf_a[i][4:3] != 2'b00) begin
          lo = lo_a[i]; hi = hi_a[i];
          fi = (a >= lo) && (a <= hi);
          li = (last >= lo) && (last <= hi);
          if (fi != li) begin
            decided = 1; part = 1; al = 3'b000;
          end else if (fi) begin
            decided = 1;
            code = {cf_a[i][7], cf_a[i][0], cf_a[i][1], cf_a[i][2]};
            if (!ld) al = (rm && !cf_a[i][7]) ? 3'b111 : cf_a[i][2:0];
            else if (rm) al = tbl_m(code);
            else al = tbl_u(code);
          end
        end
      end
    end
    if (!decided) begin
      if (wl) al = 3'b000;
      else if (ld) al = (rm && !rp[2]) ? 3'b011 : 3'b000;
      else al = rm ? 3'b111 : 3'b000;
    end
    gr = !part && ((rp & ~al) == 3'b000);
  endtask

  // reference pipeline: one stage, as R1 states
  logic       e_valid;
  logic [2:0] e_allow;
  logic       e_grant;
  string      e_tag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
    end else begin
      e_valid <= rv;
      if (rv) begin
        logic [2:0] al; logic gr;
        model(al, gr);
        e_allow <= al;
        e_grant <= gr;
        e_tag   <= cur_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      checks++;
      if (ov !== e_valid) begin
        failures++;
        $display("FAIL R1 valid actual=%0b expected=%0b", ov, e_valid);
      end
      if (e_valid) begin
        checks++;
        if (oa !== e_allow || og !== e_grant) begin
          failures++;
          $display("FAIL %s addr=%h allow actual=%b expected=%b grant actual=%0b expected=%0b",
                   e_tag, ra, oa, e_allow, og, e_grant);
        end
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input int sz, input bit m,
                      input logic [2:0] p, input string tag);
    @(negedge clk);
    cur_tag = tag;
    ra = a; rs = SW'(sz); rm = m; rp = p; rv = 1'b1;
  endtask
  task automatic idle();
    @(negedge clk);
    rv = 1'b0;
  endtask

  // explicit expectation checks at the ports
  task automatic expect_out(input logic [2:0] a, input bit g, input string tag);
    @(negedge clk);
    rv = 1'b0;
    checks++;
    if (oa !== a || og !== g) begin
      failures++;
      $display("FAIL %s allow actual=%b expected=%b grant actual=%0b expected=%0b",
               tag, oa, a, og, g);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rv = 1'b0; ra = '0; rs = '0; rm = 1'b0; rp = '0;
    wl = 1'b0; ld = 1'b0; cnt = '0;
    for (int i = 0; i < NE; i++) begin
      lo_a[i] = '0; hi_a[i] = '0; cf_a[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (ov !== 1'b0 || oa !== 3'b000 || og !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset outputs actual=%0b%b%0b expected=00000", ov, oa, og);
    end
    rst_n = 1'b1;
    run_chk = 1;

    // R5: no active rules, default for machine vs lower
    send(32'h100, 4, 1, 3'b111, "R5"); expect_out(3'b111, 1, "R5");
    send(32'h100, 4, 0, 3'b001, "R5"); expect_out(3'b000, 0, "R5");

    // R6: default ordering
    wl = 1; send(32'h100, 4, 1, 3'b001, "R6"); expect_out(3'b000, 0, "R6");
    wl = 0; ld = 1;
    send(32'h100, 4, 1, 3'b001, "R6"); expect_out(3'b011, 1, "R6");
    send(32'h100, 4, 1, 3'b100, "R6"); expect_out(3'b000, 0, "R6");
    send(32'h100, 4, 0, 3'b001, "R6"); expect_out(3'b000, 0, "R6");
    ld = 0;

    // entry table: mode field 01 marks active
    lo_a[0] = 32'h1000; hi_a[0] = 32'h10FF; cf_a[0] = 8'h09; // R
    lo_a[1] = 32'h1000; hi_a[1] = 32'h1FFF; cf_a[1] = 8'h0F; // RWX
    lo_a[2] = 32'h3000; hi_a[2] = 32'h3FFF; cf_a[2] = 8'h8B; // locked RW
    lo_a[3] = 32'h5000; hi_a[3] = 32'h5003; cf_a[3] = 8'h07; // inactive
    lo_a[4] = 32'h4000; hi_a[4] = 32'h5FFF; cf_a[4] = 8'h0B; // RW
    cnt = CW'(4);

    // R2: lowest index wins
    send(32'h1010, 4, 0, 3'b001, "R2"); expect_out(3'b001, 1, "R2");
    send(32'h1010, 4, 0, 3'b010, "R10"); expect_out(3'b001, 0, "R10");
    send(32'h1800, 4, 0, 3'b111, "R2"); expect_out(3'b111, 1, "R2");
    // R3: straddles entry 0 although entry 1 covers it
    send(32'h10FE, 4, 1, 3'b001, "R3"); expect_out(3'b000, 0, "R3");
    // R4: zero size means four bytes
    send(32'h10FC, 0, 0, 3'b001, "R4"); expect_out(3'b001, 1, "R4");
    send(32'h10FD, 0, 0, 3'b001, "R4"); expect_out(3'b000, 0, "R4");
    // R5: inactive entry 3 skipped, entry 4 decides
    send(32'h5000, 2, 0, 3'b011, "R5"); expect_out(3'b011, 1, "R5");
    // R7: machine mode unlocked vs locked
    send(32'h1010, 4, 1, 3'b100, "R7"); expect_out(3'b111, 1, "R7");
    send(32'h3000, 4, 1, 3'b100, "R7"); expect_out(3'b011, 0, "R7");

    // R8 / R9: sweep all lockdown codes on entry 0
    ld = 1;
    for (int c = 0; c < 16; c++) begin
      cf_a[0] = {c[3], 2'b00, 2'b01, c[0], c[1], c[2]};
      send(32'h1010, 4, 1, 3'b000, "R8"); expect_out(tbl_m(c), 1, "R8");
      send(32'h1010, 4, 0, 3'b000, "R9"); expect_out(tbl_u(c), 1, "R9");
    end
    ld = 0; cf_a[0] = 8'h09;

    // back-to-back mixed traffic, compared each clock by the model
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) begin
        wl = ($urandom % 4) == 0;
        ld = ($urandom % 2) == 1;
        cf_a[0] = 8'($urandom) | 8'h08;
        cf_a[0][4] = 1'b0;
      end
      send(AW'($urandom % 32'h6100), int'($urandom % 16), bit'($urandom % 2),
           3'($urandom), "R2");
    end
    idle();
    idle();
    finish_run();
  end
endmodule